// File: doc/BRIEF.md
# Hit Record Parity Serializer

This block takes one hit record, made of a column coordinate, a row coordinate and a time stamp, and sends it out on a single serial line as a fixed 44-bit frame at one bit per clock. The nominal clock is 50 MHz. Each field is followed by an even parity bit computed over that field, and then by one zero padding bit. The frame therefore has three sections of 14, 16 and 14 bits. The block is meant for moving sparse hit data off a large sensor at a steady bit rate.

Records enter through a valid/ready handshake. A record is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low through all 44 bit times, which is the back-pressure: the source must hold its record and its `in_valid` until `in_ready` returns. `in_ready` comes back high in the cycle after the last bit, so two frames sent back to back are separated by one idle cycle. On the output side there is no stall. `ser_frame` marks the 44 bit times, and `ser_oor` flags a frame whose record had a field above its nominal range. Such values are still sent as they are.

Top module: `hitser`

## Requirements
- R1: A record accepted on edge k appears on `ser_data` from the cycle after edge k, one bit per clock, for 44 bits.
- R2: The frame order is column (12 bits), then row (14 bits), then time (12 bits), each field sent most significant bit first. Frame bit 43 is sent first. Column is bits 43:32, row is bits 29:16 and time is bits 13:2.
- R3: Each field is followed directly by an even parity bit, which is the XOR of that field's data bits. These parity bits sit at frame bits 31, 15 and 1.
- R4: Each parity bit is followed by one padding bit of value 0, at frame bits 30, 14 and 0.
- R5: `in_ready` is low from the edge that accepts a record until the last of the 44 bits has been shown, and it is high again in the next cycle.
- R6: `ser_frame` is high for exactly 44 consecutive cycles per accepted record.
- R7: `ser_oor` is high for the whole frame when column > 2200, row > 12500 or time > 3000, and low otherwise. The boundary values 2200, 12500 and 3000 count as in range. The field values are still transmitted unchanged.
- R8: After reset, and whenever no frame is active, `ser_data`, `ser_frame` and `ser_oor` are 0 and `in_ready` is 1.
- R9: Input changes and `in_valid` while `in_ready` is low have no effect on the frame in progress. A record held valid across a frame is taken once, when `in_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Block can take a record |
| in_col | input | 12 | Column coordinate |
| in_row | input | 14 | Row coordinate |
| in_time | input | 12 | Time stamp |
| ser_data | output | 1 | Serial frame bit |
| ser_frame | output | 1 | High during the 44 bit times of a frame |
| ser_oor | output | 1 | Out-of-range flag for the current frame |

## Verification
The first bit of a frame is due one cycle after the accepting edge, and each later bit follows one cycle after the one before it. `in_ready` returns 44 cycles after acceptance, and `ser_oor` is valid over the same 44 cycles as `ser_frame`. The bench keeps a queue of the bits still owed, updated on each rising edge with the same accept rule the requirements give. At every falling edge it compares all four outputs against the head of that queue. This means any latency error of even one cycle shows up at once. The stimulus includes boundary values, all-ones fields, back-to-back records and a record held valid during a busy frame.

// File: rtl/hitser_pkg.sv
package hitser_pkg;
  localparam int COL_W  = 12;
  localparam int ROW_W  = 14;
  localparam int TIME_W = 12;
  localparam int COL_MAX  = 2200;
  localparam int ROW_MAX  = 12500;
  localparam int TIME_MAX = 3000;
  // each section: data, parity, pad
  localparam int COL_SEC  = COL_W + 2;
  localparam int ROW_SEC  = ROW_W + 2;
  localparam int TIME_SEC = TIME_W + 2;
  localparam int FRAME_W  = COL_SEC + ROW_SEC + TIME_SEC;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
endpackage

// File: rtl/hitser_field.sv
module hitser_field #(
  parameter int W   = 12,
  parameter int MAX = 2200
) (
  input  logic [W-1:0] val,
  output logic [W+1:0] sect,
  output logic         over
);
  logic par;
  always_comb begin
    par  = ^val;
    sect = {val, par, 1'b0};
    over = (int'(val) > MAX);
  end
endmodule

// File: rtl/hitser_framer.sv
module hitser_framer
  import hitser_pkg::*;
(
  input  logic [COL_W-1:0]   col,
  input  logic [ROW_W-1:0]   row,
  input  logic [TIME_W-1:0]  tstamp,
  output logic [FRAME_W-1:0] word,
  output logic               oor
);
  logic [COL_SEC-1:0]  s_col;
  logic [ROW_SEC-1:0]  s_row;
  logic [TIME_SEC-1:0] s_time;
  logic o_col, o_row, o_time;

  hitser_field #(.W(COL_W),  .MAX(COL_MAX))  u_col  (.val(col),    .sect(s_col),  .over(o_col));
  hitser_field #(.W(ROW_W),  .MAX(ROW_MAX))  u_row  (.val(row),    .sect(s_row),  .over(o_row));
  hitser_field #(.W(TIME_W), .MAX(TIME_MAX)) u_time (.val(tstamp), .sect(s_time), .over(o_time));

  always_comb begin
    word = {s_col, s_row, s_time};
    oor  = o_col | o_row | o_time;
  end
endmodule

// File: rtl/hitser_shifter.sv
module hitser_shifter
  import hitser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  input  logic               oor_in,
  output logic               busy,
  output logic               bit_o,
  output logic               oor_o
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               oor_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      oor_q <= 1'b0;
    end else if (load) begin
      shreg <= word;
      left  <= CNT_W'(FRAME_W);
      oor_q <= oor_in;
    end else if (left != '0) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) oor_q <= 1'b0;
    end
  end

  always_comb begin
    busy  = (left != '0);
    bit_o = busy & shreg[FRAME_W-1];
    oor_o = busy & oor_q;
  end

  // independent run-length counter for the frame strobe
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 1'b1 : '0;
  end

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == (CNT_W+1)'(FRAME_W));
  assert_frame_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < (CNT_W+1)'(FRAME_W));
  assert_oor_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(load)) |-> $stable(oor_o));
endmodule

// File: rtl/hitser.sv
module hitser
  import hitser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COL_W-1:0]  in_col,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [TIME_W-1:0] in_time,
  output logic              ser_data,
  output logic              ser_frame,
  output logic              ser_oor
);
  logic [FRAME_W-1:0] word;
  logic               oor_c;
  logic               busy;
  logic               accept;

  hitser_framer u_framer (
    .col(in_col), .row(in_row), .tstamp(in_time),
    .word(word), .oor(oor_c)
  );

  always_comb begin
    in_ready = ~busy;
    accept   = in_valid & ~busy;
  end

  hitser_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(word), .oor_in(oor_c),
    .busy(busy), .bit_o(ser_data), .oor_o(ser_oor)
  );

  assign ser_frame = busy;

  assert_first_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (ser_frame && ser_data == $past(in_col[COL_W-1])));
  assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |-> !in_ready);
  assert_oor_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oor |-> ser_frame);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_frame |-> !ser_data);
endmodule

// File: tb/hitser_tb.sv
module hitser_tb;
  localparam int CLK_PERIOD = 20;
  localparam int FW = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_col = '0;
  logic [13:0] in_row = '0;
  logic [11:0] in_time = '0;
  logic ser_data, ser_frame, ser_oor;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hitser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_col(in_col), .in_row(in_row), .in_time(in_time),
    .ser_data(ser_data), .ser_frame(ser_frame), .ser_oor(ser_oor)
  );

  // reference model: bits still owed, plus the flag of the current frame
  bit q[$];
  bit m_oor = 0;

  task automatic push_frame(input int c, input int r, input int t);
    bit p;
    p = 0;
    for (int i = 11; i >= 0; i--) begin q.push_back(c[i]); p ^= c[i]; end
    q.push_back(p); q.push_back(1'b0);
    p = 0;
    for (int i = 13; i >= 0; i--) begin q.push_back(r[i]); p ^= r[i]; end
    q.push_back(p); q.push_back(1'b0);
    p = 0;
    for (int i = 11; i >= 0; i--) begin q.push_back(t[i]); p ^= t[i]; end
    q.push_back(p); q.push_back(1'b0);
    m_oor = (c > 2200) || (r > 12500) || (t > 3000);
  endtask

  always @(posedge clk) begin
    bit acc;
    cycles++;
    if (!rst_n) begin
      q.delete();
      m_oor = 0;
    end else begin
      acc = in_valid && (q.size() == 0);
      if (q.size() > 0) void'(q.pop_front());
      if (acc) push_frame(int'(in_col), int'(in_row), int'(in_time));
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit live;
      live = (q.size() > 0);
      chk("R5 in_ready", in_ready, !live);
      chk("R6 ser_frame", ser_frame, live);
      chk("R1,R2,R3,R4,R9 ser_data", ser_data, live ? q[0] : 1'b0);
      chk("R7 ser_oor", ser_oor, live ? m_oor : 1'b0);
    end
  end

  task automatic send(input int c, input int r, input int t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_col = 12'(c); in_row = 14'(r); in_time = 12'(t);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset ready", in_ready, 1'b1);
    chk("R8 reset frame", ser_frame, 1'b0);
    chk("R8 reset data", ser_data, 1'b0);
    chk("R8 reset oor", ser_oor, 1'b0);

    send(12'h5A3 & 12'hFFF, 14'h1234, 12'h0F0);
    send(2200, 12500, 3000);          // R7 boundaries, in range
    send(2201, 0, 0);                 // R7 column over
    send(0, 12501, 0);                // R7 row over
    send(0, 0, 3001);                 // R7 time over
    send(4095, 16383, 4095);          // all ones
    send(0, 0, 0);
    send(1, 2, 4);

    // R9: hold valid with changing data through a busy frame
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_col = 12'd77; in_row = 14'd99; in_time = 12'd5; in_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      in_col = 12'(k * 37); in_row = 14'(k * 911); in_time = 12'(k * 13);
      @(negedge clk);
    end
    in_col = 12'd1000; in_row = 14'd13000; in_time = 12'd10;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;

    repeat (60) @(negedge clk);
    chk("R8 idle frame", ser_frame, 1'b0);
    chk("R8 idle data", ser_data, 1'b0);
    finish_all();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_all();
  end
endmodule